// File: doc/BRIEF.md
# Port-Multiplexed Image Pattern Replayer

This block plays a stored test picture out toward two serializer lanes so that a data handling unit under test sees what looks like a multi-port imaging payload. Before replay, a host loads pixel words into an external synchronous memory through a small command interface. The same interface sets the region of memory to replay, the number of output ports to emulate, and the pixel depth.

Every frame-start strobe from the unit under test re-arms a read sweep over the programmed region. Each memory word holds one pixel per lane. The block masks each pixel to the configured depth, fits it onto a 13-bit lane bus and tags the beat with a port index. The port index steps round-robin from port 0 after every strobe. The whole block runs on the link clock supplied by the unit under test.

Top module: `image_replayer`

## Requirements
- R1: While reset is held, and after it until the first sweep, `lane_valid`, `lane_data`, `mem_we` and `mem_re` are all 0.
- R2: A command with opcode 1 (write-data) drives `mem_we`=1 in the same cycle, with `mem_wdata` equal to the operand and `mem_waddr` equal to the write pointer. The pointer starts at 0, steps by one after each write, and wraps modulo the memory size.
- R3: Opcode 6 (reset-pointer) sets the write pointer to 0, so the next write-data lands at address 0.
- R4: A frame-start strobe starts a sweep of L consecutive addresses from the programmed start address, where L is the programmed length. Addresses wrap modulo the memory size. Exactly L valid beats come out, one per clock, back to back and in address order. Opcode 2 sets the start address from the low address bits of the operand. Opcode 3 sets the length, and an operand larger than the memory size is clamped to the memory size.
- R5: A strobe with a programmed length of 0 produces no valid beat and no memory read.
- R6: Opcode 4 sets the port count P; an operand of 0 gives 1, and an operand above MAX_PORTS gives MAX_PORTS. The k-th beat of a sweep (k from 0) carries `lane_port` = k mod P.
- R7: Lane 0 carries bits [15:0] of the memory word, and lane 1 carries bits [31:16]. Opcode 5 sets the depth D, clamped to 7..16. Each pixel is first masked to its low D bits. For D up to 13 it is right-aligned and the upper lane bits are 0. For D above 13 it is shifted right by D-13, keeping its 13 most significant bits. `lane_data` is 0 whenever `lane_valid` is 0.
- R8: A strobe during a sweep aborts it. No beat of the old sweep appears after the strobe edge, and a fresh sweep starts from the start address at port 0.
- R9: Opcodes 0 and 7 to 15 have no effect: no memory write and no change of start, length, port count or depth.
- R10: The first beat of a sweep is valid at the output in the second clock after the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock from the unit under test |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe marking a new frame |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_arg | input | 32 | Command operand |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | ADDR_W | Memory write address |
| mem_wdata | output | NUM_LANES*PIX_W | Memory write data |
| mem_re | output | 1 | Memory read enable |
| mem_raddr | output | ADDR_W | Memory read address |
| mem_rdata | input | NUM_LANES*PIX_W | Memory read data, valid one clock after the read |
| lane_valid | output | 1 | Lane beat valid |
| lane_port | output | PORT_W | Emulated port index of the beat |
| lane_data | output | NUM_LANES*LANE_W | Lane buses, lane 0 in the low bits |

## Verification
The bench builds the block with ADDR_W=6 and MAX_PORTS=4. A 64-word region makes address wrap and the length clamp reachable within a few dozen cycles. A port limit of 4 lets an operand of 7 exercise the port-count clamp. Depth settings of 4, 8, 12, 13, 16 and 20 cover both clamp ends, the plain right-aligned case and the shift-down case above the lane width.

// File: rtl/replay_pkg.sv
`timescale 1ns/1ps
// Shared opcode encoding for the image replayer command interface.
package replay_pkg;
    typedef enum logic [3:0] {
        OP_WRITE  = 4'd1,
        OP_START  = 4'd2,
        OP_LENGTH = 4'd3,
        OP_PORTS  = 4'd4,
        OP_DEPTH  = 4'd5,
        OP_RSTPTR = 4'd6
    } op_e;
endpackage

// File: rtl/replay_cmd_regs.sv
`timescale 1ns/1ps
// Command register file: decodes opcodes, owns the memory write pointer
// and holds the clamped replay configuration.
// Assumes at most one command per cycle; the write path is combinational.
module replay_cmd_regs
    import replay_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int WORD_W    = 32,
    parameter int MAX_PORTS = 8,
    parameter int PIX_W     = 16,
    parameter int MIN_DEPTH = 7,
    localparam int LEN_W    = ADDR_W + 1,
    localparam int CNT_W    = $clog2(MAX_PORTS + 1),
    localparam int DEPTH_W  = $clog2(PIX_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [3:0]         cmd_op,
    input  logic [31:0]        cmd_arg,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_waddr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic [ADDR_W-1:0]  cfg_start,
    output logic [LEN_W-1:0]   cfg_len,
    output logic [CNT_W-1:0]   cfg_ports,
    output logic [DEPTH_W-1:0] cfg_depth
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1) << ADDR_W;

    logic [ADDR_W-1:0] wr_ptr;
    logic              is_write;
    logic              is_known;

    // Decode the command class.
    always_comb begin
        is_write = cmd_valid && (cmd_op == OP_WRITE);
        is_known = (cmd_op >= OP_WRITE) && (cmd_op <= OP_RSTPTR);
    end

    // Memory write port straight from a write-data command.
    always_comb begin
        mem_we    = is_write;
        mem_waddr = wr_ptr;
        mem_wdata = WORD_W'(cmd_arg);
    end

    // Update the write pointer and the clamped configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            cfg_start <= '0;
            cfg_len   <= '0;
            cfg_ports <= CNT_W'(1);
            cfg_depth <= DEPTH_W'(PIX_W);
        end else if (cmd_valid) begin
            case (cmd_op)
                OP_WRITE:  wr_ptr <= wr_ptr + ADDR_W'(1);
                OP_RSTPTR: wr_ptr <= '0;
                OP_START:  cfg_start <= cmd_arg[ADDR_W-1:0];
                OP_LENGTH: cfg_len <= (cmd_arg > 32'(MAX_LEN)) ? MAX_LEN : LEN_W'(cmd_arg);
                OP_PORTS: begin
                    if (cmd_arg == 32'd0)                 cfg_ports <= CNT_W'(1);
                    else if (cmd_arg > 32'(MAX_PORTS))    cfg_ports <= CNT_W'(MAX_PORTS);
                    else                                  cfg_ports <= CNT_W'(cmd_arg);
                end
                OP_DEPTH: begin
                    if (cmd_arg < 32'(MIN_DEPTH))         cfg_depth <= DEPTH_W'(MIN_DEPTH);
                    else if (cmd_arg > 32'(PIX_W))        cfg_depth <= DEPTH_W'(PIX_W);
                    else                                  cfg_depth <= DEPTH_W'(cmd_arg);
                end
                default: ;
            endcase
        end
    end

    // R2: each write-data command advances the pointer by one.
    p_wr_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_write |=> (wr_ptr == $past(wr_ptr) + ADDR_W'(1)));

    // R3: reset-pointer returns the pointer to address 0.
    p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RSTPTR) |=> (wr_ptr == '0));

    // R9: an unknown opcode leaves every configuration register alone.
    p_bad_op_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !is_known) |=> ($stable(cfg_start) && $stable(cfg_len)
                                     && $stable(cfg_ports) && $stable(cfg_depth)
                                     && $stable(wr_ptr)));
endmodule

// File: rtl/replay_addr_seq.sv
`timescale 1ns/1ps
// Address sequencer: on each frame-start strobe loads the start address
// and length, then issues one memory read per clock with a round-robin
// port tag. Assumes the memory returns data one clock after a read.
module replay_addr_seq #(
    parameter int ADDR_W    = 10,
    parameter int MAX_PORTS = 8,
    localparam int LEN_W    = ADDR_W + 1,
    localparam int CNT_W    = $clog2(MAX_PORTS + 1),
    localparam int PORT_W   = (MAX_PORTS > 1) ? $clog2(MAX_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [CNT_W-1:0]  cfg_ports,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              beat_vld,
    output logic [PORT_W-1:0] beat_port
);
    logic [ADDR_W-1:0] rd_addr;
    logic [LEN_W-1:0]  remain;
    logic [PORT_W-1:0] port_ctr;
    logic              port_last;

    // Read request while addresses remain in the sweep.
    always_comb begin
        mem_re    = (remain != '0);
        mem_raddr = rd_addr;
        port_last = (CNT_W'(port_ctr) + CNT_W'(1)) >= cfg_ports;
    end

    // Sweep state: restart on strobe, otherwise step address, count and port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr  <= '0;
            remain   <= '0;
            port_ctr <= '0;
        end else if (frame_start) begin
            rd_addr  <= cfg_start;
            remain   <= cfg_len;
            port_ctr <= '0;
        end else if (mem_re) begin
            rd_addr  <= rd_addr + ADDR_W'(1);
            remain   <= remain - LEN_W'(1);
            port_ctr <= port_last ? '0 : port_ctr + PORT_W'(1);
        end
    end

    // Tag travelling with the read, squashed when a strobe aborts the sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_vld  <= 1'b0;
            beat_port <= '0;
        end else begin
            beat_vld  <= mem_re && !frame_start;
            beat_port <= port_ctr;
        end
    end

    // R4: consecutive reads of one sweep use consecutive addresses.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !frame_start) |=> (!mem_re || mem_raddr == $past(mem_raddr) + ADDR_W'(1)));

    // R5: a zero-length sweep issues no read.
    p_len_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && cfg_len == '0) |=> !mem_re);

    // R6: the first read after a strobe is tagged port 0.
    p_port_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && cfg_len != '0) |=> (mem_re && port_ctr == '0));
endmodule

// File: rtl/replay_port_mux.sv
`timescale 1ns/1ps
// Port multiplexer: splits each memory word into one pixel per lane,
// masks it to the configured depth, fits it onto the lane width and
// registers the lane beat with its port tag.
module replay_port_mux #(
    parameter int NUM_LANES = 2,
    parameter int LANE_W    = 13,
    parameter int PIX_W     = 16,
    parameter int MAX_PORTS = 8,
    localparam int WORD_W   = NUM_LANES * PIX_W,
    localparam int DEPTH_W  = $clog2(PIX_W + 1),
    localparam int PORT_W   = (MAX_PORTS > 1) ? $clog2(MAX_PORTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start,
    input  logic                        beat_vld,
    input  logic [PORT_W-1:0]           beat_port,
    input  logic [WORD_W-1:0]           mem_rdata,
    input  logic [DEPTH_W-1:0]          cfg_depth,
    output logic                        lane_valid,
    output logic [PORT_W-1:0]           lane_port,
    output logic [NUM_LANES*LANE_W-1:0] lane_data
);
    logic [PIX_W-1:0]   depth_mask;
    logic [DEPTH_W-1:0] down_shift;
    logic               take;

    // Depth mask and the shift that keeps the top bits of wide pixels.
    always_comb begin
        depth_mask = ~({PIX_W{1'b1}} << cfg_depth);
        down_shift = (cfg_depth > DEPTH_W'(LANE_W)) ? cfg_depth - DEPTH_W'(LANE_W) : '0;
        take       = beat_vld && !frame_start;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_LANES; g++) begin : g_lane
            logic [PIX_W-1:0] pix_masked;
            // Mask this lane's pixel to the configured depth.
            always_comb pix_masked = mem_rdata[g*PIX_W +: PIX_W] & depth_mask;
            // Register the fitted pixel, zero when no beat is taken.
            always_ff @(posedge clk) begin
                if (!rst_n) lane_data[g*LANE_W +: LANE_W] <= '0;
                else        lane_data[g*LANE_W +: LANE_W] <= take ? LANE_W'(pix_masked >> down_shift) : '0;
            end
        end
    endgenerate

    // Register beat valid and port tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_valid <= 1'b0;
            lane_port  <= '0;
        end else begin
            lane_valid <= take;
            lane_port  <= beat_port;
        end
    end

    // R8: nothing of an aborted sweep leaves after the strobe edge.
    p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !lane_valid);

    // R7: idle lanes are driven to zero.
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_valid |-> (lane_data == '0));

    // R10: a beat reaches the lanes one clock after its read data returns.
    p_beat_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && !frame_start) |=> lane_valid);
endmodule

// File: rtl/image_replayer.sv
`timescale 1ns/1ps
// Image pattern replayer top: command register file, address sequencer
// and port multiplexer around an external synchronous memory with a
// one-clock read latency. Runs entirely on the unit-under-test link clock.
module image_replayer #(
    parameter int ADDR_W    = 10,
    parameter int MAX_PORTS = 8,
    parameter int NUM_LANES = 2,
    parameter int LANE_W    = 13,
    parameter int PIX_W     = 16,
    parameter int MIN_DEPTH = 7,
    localparam int WORD_W   = NUM_LANES * PIX_W,
    localparam int LEN_W    = ADDR_W + 1,
    localparam int CNT_W    = $clog2(MAX_PORTS + 1),
    localparam int DEPTH_W  = $clog2(PIX_W + 1),
    localparam int PORT_W   = (MAX_PORTS > 1) ? $clog2(MAX_PORTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start,
    input  logic                        cmd_valid,
    input  logic [3:0]                  cmd_op,
    input  logic [31:0]                 cmd_arg,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_waddr,
    output logic [WORD_W-1:0]           mem_wdata,
    output logic                        mem_re,
    output logic [ADDR_W-1:0]           mem_raddr,
    input  logic [WORD_W-1:0]           mem_rdata,
    output logic                        lane_valid,
    output logic [PORT_W-1:0]           lane_port,
    output logic [NUM_LANES*LANE_W-1:0] lane_data
);
    logic [ADDR_W-1:0]  cfg_start;
    logic [LEN_W-1:0]   cfg_len;
    logic [CNT_W-1:0]   cfg_ports;
    logic [DEPTH_W-1:0] cfg_depth;
    logic               beat_vld;
    logic [PORT_W-1:0]  beat_port;

    replay_cmd_regs #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .MAX_PORTS(MAX_PORTS),
        .PIX_W(PIX_W), .MIN_DEPTH(MIN_DEPTH)
    ) cmd_regs_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .cfg_start(cfg_start), .cfg_len(cfg_len),
        .cfg_ports(cfg_ports), .cfg_depth(cfg_depth)
    );

    replay_addr_seq #(
        .ADDR_W(ADDR_W), .MAX_PORTS(MAX_PORTS)
    ) addr_seq_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_start(cfg_start), .cfg_len(cfg_len), .cfg_ports(cfg_ports),
        .mem_re(mem_re), .mem_raddr(mem_raddr),
        .beat_vld(beat_vld), .beat_port(beat_port)
    );

    replay_port_mux #(
        .NUM_LANES(NUM_LANES), .LANE_W(LANE_W), .PIX_W(PIX_W), .MAX_PORTS(MAX_PORTS)
    ) port_mux_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .beat_vld(beat_vld), .beat_port(beat_port),
        .mem_rdata(mem_rdata), .cfg_depth(cfg_depth),
        .lane_valid(lane_valid), .lane_port(lane_port), .lane_data(lane_data)
    );

    // R1: no memory activity and no beat while reset is held.
    p_reset_quiet_r1: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (!lane_valid && !mem_re));
endmodule

// File: tb/image_replayer_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: vector table of sweep configurations, then
// directed tests for reset, pointer reset, abort and ignored opcodes.
module image_replayer_tb_top;
    localparam int AW = 6;
    localparam int MEMSZ = 1 << AW;
    localparam int MP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [31:0] cmd_arg = 32'd0;
    logic        mem_we;
    logic [AW-1:0] mem_waddr;
    logic [31:0] mem_wdata;
    logic        mem_re;
    logic [AW-1:0] mem_raddr;
    logic [31:0] mem_rdata = 32'd0;
    logic        lane_valid;
    logic [1:0]  lane_port;
    logic [25:0] lane_data;

    always #2.5 clk = ~clk;

    image_replayer #(.ADDR_W(AW), .MAX_PORTS(MP)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .lane_valid(lane_valid), .lane_port(lane_port), .lane_data(lane_data)
    );

    // External memory model: synchronous write, one-clock read.
    logic [31:0] mem_model [0:MEMSZ-1];
    always @(posedge clk) begin
        if (mem_we) mem_model[mem_waddr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem_model[mem_raddr];
    end

    int n_checks = 0;
    int n_errors = 0;
    int cyc_count = 0;
    logic [31:0] shadow [0:MEMSZ-1];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc_count++;
        if (cyc_count > 100000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cyc_count);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    function automatic logic [31:0] pattern(input int i);
        logic [15:0] lo, hi;
        lo = 16'(i * 977 + 16'h5A3C);
        hi = 16'(16'hFFFF - i * 613);
        return {hi, lo};
    endfunction

    function automatic logic [12:0] exp_lane(input logic [15:0] pix, input int d);
        logic [15:0] v;
        v = (d >= 16) ? pix : (pix & 16'((1 << d) - 1));
        if (d > 13) v = v >> (d - 13);
        return v[12:0];
    endfunction

    function automatic int clamp_ports(input int p);
        return (p == 0) ? 1 : ((p > MP) ? MP : p);
    endfunction

    function automatic int clamp_depth(input int d);
        return (d < 7) ? 7 : ((d > 16) ? 16 : d);
    endfunction

    task automatic send(input logic [3:0] op, input logic [31:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_arg = arg;
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = 4'd0;
        cmd_arg = 32'd0;
    endtask

    // Write one word and check the write port in the same cycle.
    task automatic write_word(input int exp_addr, input logic [31:0] w);
        send(4'd1, w);
        #1;
        chk(mem_we && mem_waddr == AW'(exp_addr) && mem_wdata == w, "R2 write port",
            {mem_we, mem_waddr, mem_wdata}, {1'b1, AW'(exp_addr), w});
        shadow[exp_addr] = w;
    endtask

    // Captured beats.
    logic [12:0] got_l0 [0:127];
    logic [12:0] got_l1 [0:127];
    logic [1:0]  got_p  [0:127];
    int          got_c  [0:127];
    int          ngot;

    task automatic pulse_and_wait(input int n);
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic run_sweep(input int wait_cycles);
        @(negedge clk);
        frame_start = 1'b1;
        ngot = 0;
        for (int c = 1; c <= wait_cycles; c++) begin
            @(negedge clk);
            frame_start = 1'b0;
            #1;
            if (lane_valid && ngot < 128) begin
                got_l0[ngot] = lane_data[12:0];
                got_l1[ngot] = lane_data[25:13];
                got_p[ngot]  = lane_port;
                got_c[ngot]  = c;
                ngot++;
            end
        end
    endtask

    task automatic compare(input int start, input int len, input int ports, input int depth);
        chk(ngot == len, "R4/R5 beat count", ngot, len);
        for (int k = 0; k < ngot && k < len; k++) begin
            int a;
            logic [12:0] e0, e1;
            a  = (start + k) % MEMSZ;
            e0 = exp_lane(shadow[a][15:0], depth);
            e1 = exp_lane(shadow[a][31:16], depth);
            chk(got_l0[k] == e0 && got_l1[k] == e1, "R7 lane data", {got_l1[k], got_l0[k]}, {e1, e0});
            chk(got_p[k] == 2'(k % ports), "R6 port tag", got_p[k], k % ports);
            chk(got_c[k] == 3 + k, "R10/R4 beat timing", got_c[k], 3 + k);
        end
    endtask

    typedef struct packed {
        logic [7:0] start;
        logic [7:0] len;
        logic [7:0] ports;
        logic [7:0] depth;
        logic [7:0] exp_beats;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{8'd0,  8'd8,   8'd1, 8'd8,  8'd8},
        '{8'd5,  8'd12,  8'd3, 8'd13, 8'd12},
        '{8'd60, 8'd10,  8'd4, 8'd16, 8'd10},
        '{8'd20, 8'd7,   8'd0, 8'd7,  8'd7},
        '{8'd33, 8'd9,   8'd7, 8'd4,  8'd9},
        '{8'd10, 8'd0,   8'd2, 8'd10, 8'd0},
        '{8'd0,  8'd100, 8'd2, 8'd12, 8'd64},
        '{8'd50, 8'd5,   8'd2, 8'd20, 8'd5}
    };

    initial begin
        // R1: outputs quiet during reset.
        repeat (3) @(negedge clk);
        chk(!lane_valid && lane_data == 26'd0, "R1 lanes in reset", {lane_valid, lane_data}, 0);
        chk(!mem_re && !mem_we, "R1 memory idle in reset", {mem_re, mem_we}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!lane_valid && !mem_re && lane_data == 26'd0, "R1 quiet after reset",
            {lane_valid, mem_re, lane_data}, 0);

        // R3: partial load, pointer reset, then full load from address 0.
        for (int i = 0; i < 10; i++) write_word(i, 32'hDEAD0000 + i);
        send(4'd6, 32'd0);
        for (int i = 0; i < MEMSZ; i++) begin
            write_word(i, pattern(i));
            if (i == 0)
                chk(mem_waddr == AW'(0), "R3 pointer reset", mem_waddr, 0);
        end
        idle();

        // Vector table of sweep configurations.
        for (int v = 0; v < NVEC; v++) begin
            int pe, de;
            send(4'd2, 32'(VECS[v].start));
            send(4'd3, 32'(VECS[v].len));
            send(4'd4, 32'(VECS[v].ports));
            send(4'd5, 32'(VECS[v].depth));
            idle();
            pe = clamp_ports(int'(VECS[v].ports));
            de = clamp_depth(int'(VECS[v].depth));
            run_sweep(int'(VECS[v].exp_beats) + 6);
            compare(int'(VECS[v].start), int'(VECS[v].exp_beats), pe, de);
            if (VECS[v].len == 8'd0)
                chk(ngot == 0, "R5 zero length silent", ngot, 0);
        end

        // R8: abort a long sweep mid-way and restart.
        send(4'd2, 32'd8);
        send(4'd3, 32'd40);
        send(4'd4, 32'd3);
        send(4'd5, 32'd16);
        idle();
        pulse_and_wait(12);
        run_sweep(46);
        chk(ngot == 40, "R8 restart full length", ngot, 40);
        chk(ngot > 0 && got_p[0] == 2'd0, "R8 restart port 0", got_p[0], 0);
        compare(8, 40, 3, 16);

        // R9: unknown opcodes do nothing.
        send(4'd2, 32'd2);
        send(4'd3, 32'd6);
        send(4'd4, 32'd2);
        send(4'd5, 32'd9);
        send(4'd7, 32'd30);
        #1 chk(!mem_we, "R9 op7 no write", mem_we, 0);
        send(4'd0, 32'd1);
        #1 chk(!mem_we, "R9 op0 no write", mem_we, 0);
        send(4'd15, 32'd3);
        #1 chk(!mem_we, "R9 op15 no write", mem_we, 0);
        send(4'd9, 32'd11);
        idle();
        run_sweep(12);
        chk(ngot == 6, "R9 length unchanged", ngot, 6);
        compare(2, 6, 2, 9);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule